// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This block keeps a 64-bit up-counting time base and a 32-bit down-counting decrementer for a processor core. Both counters share a single prescaler that turns the bus clock into one count step for every four clock cycles. Software reaches the counters through a small register port. The time base appears as a lower and an upper 32-bit half. The decrementer is a single 32-bit register. An external enable input can freeze the time base without touching the decrementer.

The decrementer raises an exception request when its count steps through zero. The request stays pending until it is acknowledged. An external mask input can hide the request without losing it. The timer has no dependency on the core's activity, so it keeps counting while the core sits in a low-power state.

Top module: `tbdec_timer`

## Requirements
- R1: After synchronous reset, both time base halves and the decrementer read zero, the prescaler phase is zero and no exception is requested.
- R2: While `tb_count_en` is high, the 64-bit time base increases by exactly one on each prescaled step. A step occurs on every fourth rising clock edge counted from the last phase restart.
- R3: The decrementer decreases by exactly one on each prescaled step and holds its value on every other clock edge.
- R4: When the lower time base half is all ones, a step sets it to zero and increments the upper half on the same clock edge.
- R5: A pending exception is set only when a step takes the decrementer from 0x00000000 to 0xFFFFFFFF, which is seen as its most-significant bit rising through the decrement. Holding the value zero does not set it. Writing 0xFFFFFFFF does not set it.
- R6: A pending exception stays set until `exc_ack` is high at a clock edge, and then it clears. If a new wrap happens on that same edge, the set wins.
- R7: `exc_req` is the pending flag gated by `exc_mask`. While the mask is high the output is low, but the pending flag is kept, and the request appears as soon as the mask drops.
- R8: While `tb_count_en` is low, the time base holds. The decrementer keeps stepping.
- R9: A register write is visible on the read port after the next rising edge. It restarts the prescaler phase at zero, so the next step comes four edges later. A step that would fall on the write's edge is dropped for both counters.
- R10: Register select encoding: 0 is the time base lower half, 1 is the time base upper half, 2 is the decrementer, and 3 is unused. Select 3 reads as zero. A write to select 3 changes no counter and does not restart the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 2 | Register select (see R10) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register, combinational |
| tb_count_en | input | 1 | Time base count enable |
| exc_mask | input | 1 | High hides the exception request |
| exc_ack | input | 1 | Clears the pending exception |
| exc_req | output | 1 | Decrementer exception request |

## Verification
The bench builds the block with its default parameters: 32-bit halves, a 32-bit decrementer and a prescale of four. Steps therefore arrive every fourth clock, so each step boundary can be exercised in a handful of cycles. The full 64-bit carry and the 32-bit wrap are reached by loading values just below the boundary through the write port, not by counting up to them. Phase restarts, the masked-but-pending state and the write to the unused select are each observed at the read port and the request output.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        SEL_TB_LO = 2'd0,
        SEL_TB_HI = 2'd1,
        SEL_DEC   = 2'd2,
        SEL_NONE  = 2'd3
    } tbdec_sel_e;

    typedef struct packed {
        logic tb_lo;
        logic tb_hi;
        logic dec;
    } tbdec_wr_s;

    function automatic tbdec_wr_s decode_wr(input logic wr, input logic [1:0] sel);
        tbdec_wr_s w;
        w.tb_lo = wr && (sel == SEL_TB_LO);
        w.tb_hi = wr && (sel == SEL_TB_HI);
        w.dec   = wr && (sel == SEL_DEC);
        return w;
    endfunction

    function automatic logic any_wr(input tbdec_wr_s w);
        return w.tb_lo | w.tb_hi | w.dec;
    endfunction

endpackage

// File: rtl/tbdec_prescaler.sv
module tbdec_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (restart || phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = (phase == LAST) && !restart;

    // R3: the phase never leaves its range
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);

    // R9: a restart puts the phase back to zero
    p_restart_phase_r9: assert property (@(posedge clk) disable iff (rst)
        restart |=> phase == '0);

endmodule

// File: rtl/tbdec_timebase.sv
module tbdec_timebase #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              count_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] tb_lo,
    output logic [HALF_W-1:0] tb_hi
);
    logic step;
    logic lo_carry;

    assign step     = tick && count_en;
    assign lo_carry = &tb_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_lo <= '0;
        end else if (wr_lo) begin
            tb_lo <= wdata;
        end else if (step) begin
            tb_lo <= tb_lo + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_hi <= '0;
        end else if (wr_hi) begin
            tb_hi <= wdata;
        end else if (step && lo_carry) begin
            tb_hi <= tb_hi + 1'b1;
        end
    end

    // R2 and R4: the full 64-bit value steps by one, with carry
    p_tb_step_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_lo && !wr_hi) |=> {tb_hi, tb_lo} == $past({tb_hi, tb_lo}) + 1'b1);

    // R8: frozen while disabled
    p_tb_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !wr_lo && !wr_hi) |=> $stable({tb_hi, tb_lo}));

endmodule

// File: rtl/tbdec_decrementer.sv
module tbdec_decrementer #(
    parameter int DEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr,
    input  logic [DEC_W-1:0] wdata,
    input  logic             ack,
    output logic [DEC_W-1:0] dec,
    output logic             pending
);
    logic [DEC_W-1:0] dec_next;
    logic             wrap;

    assign dec_next = dec - 1'b1;
    assign wrap     = tick && !dec[DEC_W-1] && dec_next[DEC_W-1] && (dec == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec <= '0;
        end else if (wr) begin
            dec <= wdata;
        end else if (tick) begin
            dec <= dec_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (wrap) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

    // R3: no change without a step or a write
    p_dec_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr) |=> $stable(dec));

    // R5: stepping from zero lands on all ones and sets pending
    p_wrap_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && dec == '0) |=> (pending && dec == '1));

    // R6: pending survives until acknowledged
    p_pending_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (pending && !ack) |=> pending);

    // R5: no pending without a wrap
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        (!pending && !(tick && dec == '0)) |=> !pending);

endmodule

// File: rtl/tbdec_timer.sv
module tbdec_timer
    import tbdec_pkg::*;
#(
    parameter int HALF_W   = REG_W,
    parameter int DEC_W    = REG_W,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    input  logic              tb_count_en,
    input  logic              exc_mask,
    input  logic              exc_ack,
    output logic              exc_req
);
    localparam int DEC_PAD = HALF_W - DEC_W;

    tbdec_wr_s        wr_dec;
    logic             restart;
    logic             tick;
    logic [HALF_W-1:0] tb_lo;
    logic [HALF_W-1:0] tb_hi;
    logic [DEC_W-1:0]  dec;
    logic             pending;

    assign wr_dec  = decode_wr(reg_wr, reg_sel);
    assign restart = any_wr(wr_dec);

    tbdec_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick)
    );

    tbdec_timebase #(.HALF_W(HALF_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .count_en (tb_count_en),
        .wr_lo    (wr_dec.tb_lo),
        .wr_hi    (wr_dec.tb_hi),
        .wdata    (reg_wdata),
        .tb_lo    (tb_lo),
        .tb_hi    (tb_hi)
    );

    tbdec_decrementer #(.DEC_W(DEC_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr      (wr_dec.dec),
        .wdata   (reg_wdata[DEC_W-1:0]),
        .ack     (exc_ack),
        .dec     (dec),
        .pending (pending)
    );

    always_comb begin
        case (tbdec_sel_e'(reg_sel))
            SEL_TB_LO: reg_rdata = tb_lo;
            SEL_TB_HI: reg_rdata = tb_hi;
            SEL_DEC:   reg_rdata = {{DEC_PAD{1'b0}}, dec};
            default:   reg_rdata = '0;
        endcase
    end

    assign exc_req = pending && !exc_mask;

    // R9: a decrementer write is what the register holds one edge later
    p_dec_write_visible_r9: assert property (@(posedge clk) disable iff (rst)
        wr_dec.dec |=> dec == $past(reg_wdata[DEC_W-1:0]));

    // R10: a write to the unused select leaves the counters unstepped by it
    p_unused_sel_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == SEL_NONE && !tick) |=> $stable(dec));

endmodule

// File: tb/tb_tbdec_timer.sv
module tb_tbdec_timer;
    import tbdec_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tb_count_en = 1'b1;
    logic        exc_mask = 1'b0;
    logic        exc_ack = 1'b0;
    logic        exc_req;

    always #5 clk = ~clk;

    tbdec_timer dut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .tb_count_en (tb_count_en),
        .exc_mask    (exc_mask),
        .exc_ack     (exc_ack),
        .exc_req     (exc_req)
    );

    typedef struct {
        bit          is_exc;
        logic [1:0]  sel;
        logic [31:0] exp;
        int          req;
    } item_t;

    item_t sb[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // monitor: compares the oldest expected item against the ports
    initial begin
        item_t it;
        logic [31:0] act;
        forever begin
            wait (sb.size() > 0);
            #0.1;
            it  = sb[0];
            act = it.is_exc ? {31'd0, exc_req} : reg_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL R%0d sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
            void'(sb.pop_front());
        end
    end

    task automatic expect_reg(input logic [1:0] sel, input logic [31:0] exp, input int req);
        item_t it;
        reg_sel = sel;
        it.is_exc = 1'b0; it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic expect_exc(input logic v, input int req);
        item_t it;
        it.is_exc = 1'b1; it.sel = reg_sel; it.exp = {31'd0, v}; it.req = req;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] val);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ack_exc();
        exc_ack = 1'b1;
        @(negedge clk);
        exc_ack = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        // R1: reset state
        expect_reg(SEL_TB_LO, 32'd0, 1);
        expect_reg(SEL_TB_HI, 32'd0, 1);
        expect_reg(SEL_DEC, 32'd0, 1);
        expect_exc(1'b0, 1);

        // R2/R3/R5: first step four edges after reset
        step(4);
        expect_reg(SEL_TB_LO, 32'd1, 2);
        expect_reg(SEL_TB_HI, 32'd0, 2);
        expect_reg(SEL_DEC, 32'hFFFF_FFFF, 3);
        expect_exc(1'b1, 5);
        ack_exc();
        expect_exc(1'b0, 6);

        // R9/R3: load and count down
        write_reg(SEL_DEC, 32'd5);
        expect_reg(SEL_DEC, 32'd5, 9);
        step(3);
        expect_reg(SEL_DEC, 32'd5, 3);
        step(1);
        expect_reg(SEL_DEC, 32'd4, 3);
        step(16);
        expect_reg(SEL_DEC, 32'd0, 3);
        expect_exc(1'b0, 5);   // R5: zero alone does not fire
        step(4);
        expect_reg(SEL_DEC, 32'hFFFF_FFFF, 5);
        expect_exc(1'b1, 5);
        ack_exc();
        expect_exc(1'b0, 6);

        // R7: masked wrap is held
        exc_mask = 1'b1;
        write_reg(SEL_DEC, 32'd1);
        step(8);
        expect_reg(SEL_DEC, 32'hFFFF_FFFF, 7);
        expect_exc(1'b0, 7);
        step(4);
        exc_mask = 1'b0;
        expect_exc(1'b1, 7);   // R6: still pending after mask drops
        ack_exc();
        expect_exc(1'b0, 6);

        // R4: carry into the upper half
        write_reg(SEL_TB_HI, 32'h12);
        write_reg(SEL_TB_LO, 32'hFFFF_FFFF);
        expect_reg(SEL_TB_LO, 32'hFFFF_FFFF, 9);
        step(4);
        expect_reg(SEL_TB_LO, 32'd0, 4);
        expect_reg(SEL_TB_HI, 32'h13, 4);

        // R8: enable low freezes the time base only
        tb_count_en = 1'b0;
        write_reg(SEL_DEC, 32'd50);
        write_reg(SEL_TB_LO, 32'd100);
        step(12);
        expect_reg(SEL_TB_LO, 32'd100, 8);
        expect_reg(SEL_TB_HI, 32'h13, 8);
        expect_reg(SEL_DEC, 32'd47, 8);
        tb_count_en = 1'b1;
        step(4);
        expect_reg(SEL_TB_LO, 32'd101, 2);

        // R9: second write restarts the phase
        write_reg(SEL_DEC, 32'd10);
        step(2);
        write_reg(SEL_DEC, 32'd20);
        expect_reg(SEL_DEC, 32'd20, 9);
        step(3);
        expect_reg(SEL_DEC, 32'd20, 9);
        step(1);
        expect_reg(SEL_DEC, 32'd19, 9);

        // R10: unused select
        write_reg(SEL_NONE, 32'hDEAD_BEEF);
        expect_reg(SEL_NONE, 32'd0, 10);
        step(2);
        expect_reg(SEL_DEC, 32'd19, 10);
        step(1);
        expect_reg(SEL_DEC, 32'd18, 10);

        // R5: writing all ones does not fire
        write_reg(SEL_DEC, 32'hFFFF_FFFF);
        expect_exc(1'b0, 5);
        step(4);
        expect_reg(SEL_DEC, 32'hFFFF_FFFE, 3);
        expect_exc(1'b0, 5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule